// File: doc/BRIEF.md
# SMM address strobe steering unit

This unit decides, for every memory bus request a processor issues, whether the cycle goes to main memory (normal address strobe) or to the separate system-management memory (SMM address strobe). The decision depends on whether the processor is in normal mode or in system-management mode. It also depends on whether the request is a code fetch or a data access, on whether its address falls in a programmable SMM window, and on three control bits held in a configuration register.

The unit also tracks the mode itself. An accepted falling edge on the active-low SMI input enters system-management mode, and a one-cycle resume pulse leaves it. When software attempts an SMM-only instruction that is not allowed, the unit flags it as an invalid opcode. Software programs the control bits and the window through a two-step port: first an index write, then a data write or a data read.

Requests enter on a valid/ready channel and leave through a one-entry output register, also valid/ready. A request is taken when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high whenever the output register is empty or is being drained in the same cycle. While `bus_valid_o` is high and `bus_ready_i` is low, the output beat and its strobe are held and no new request is taken.

Top module: `smm_strobe_steer`

## Requirements
- R1: After reset all configuration bytes read 00h. Index C1h is the control byte: bit 0 enables the SMM pins, bit 1 enables SMM memory access in normal mode, bit 2 enables main memory access in SMM mode, and bits 7:3 read 0. Index C2h/C3h hold the low/high byte of the window base page, and C4h holds the window size in pages.
- R2: Any index other than C1h to C4h reads FFh, and a data write to it changes no register.
- R3: An address hits the window when its page (address bits 31:12) is at or above the base and below base plus size. A size of 0 gives no hit.
- R4: In normal mode the normal strobe is used, except when the pin enable, the normal-mode SMM access bit and a window hit are all present; that request uses the SMM strobe. Exactly one strobe is active for each output beat.
- R5: In SMM mode with the main-access bit at 0, every request uses the SMM strobe.
- R6: In SMM mode with the main-access bit at 1, data accesses in the window use the normal strobe, and this holds even when the normal-mode SMM access bit is also 1. Code fetches in the window and all accesses outside it use the SMM strobe.
- R7: With the pin enable at 0, the SMM strobe output enable is low, the SMM strobe is never driven, and SMI edges are ignored.
- R8: A falling edge on SMI in normal mode, with the pin enable at 1 and the normal-mode SMM access bit at 0, sets the mode output in the next cycle. With the SMM access bit at 1, or while already in SMM mode, the edge is ignored.
- R9: A resume pulse in SMM mode clears the mode output in the next cycle.
- R10: An SMM-only instruction indication raises the fault output in the same cycle when the pin enable is 0, or when in normal mode with the normal-mode SMM access bit at 0. Otherwise the fault stays low.
- R11: While the output beat is stalled, `req_ready_o` is low and the beat's address and strobe stay unchanged until the beat is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_idx_we | input | 1 | Load `cfg_wdata` into the index register |
| cfg_data_we | input | 1 | Write `cfg_wdata` to the indexed register |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Contents of the indexed register |
| smi_n_i | input | 1 | Active-low system-management interrupt |
| resume_i | input | 1 | One-cycle request to leave SMM mode |
| smm_insn_i | input | 1 | An SMM-only instruction is being executed |
| insn_fault_o | output | 1 | That instruction is an invalid opcode |
| smm_mode_o | output | 1 | Unit is in SMM mode |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus request accepted |
| req_addr_i | input | 32 | Request address |
| req_code_i | input | 1 | Request is a code fetch (0 = data) |
| bus_valid_o | output | 1 | Output beat valid |
| bus_ready_i | input | 1 | Downstream takes the beat |
| bus_addr_o | output | 32 | Address of the output beat |
| norm_strobe_o | output | 1 | Beat goes to main memory |
| smm_strobe_o | output | 1 | Beat goes to SMM memory |
| smm_strobe_oe_o | output | 1 | Drive enable of the SMM strobe pin |

## Verification
Requests are sent to pages just below, at the first page of, at the last page of and just past the window. This separates an off-by-one in either compare from a correct window, and a zero size shows whether the empty window is really empty. Code and data fetches to the same in-window page are sent in SMM mode with the main-access bit both clear and set, and then with both access bits set. These separate a wrong treatment of the access type from a wrong precedence between the two bits. SMI edges arrive with the pin disabled, with normal-mode access enabled and while already in SMM mode, so that each way an edge can be ignored is seen apart from a real entry. A stalled output beat followed by a second request shows whether back-pressure holds the beat or lets it be overwritten.

// File: rtl/smm_steer_pkg.sv
package smm_steer_pkg;

  localparam int CFG_W = 8;

  localparam logic [CFG_W-1:0] IDX_CTRL    = 8'hC1;
  localparam logic [CFG_W-1:0] IDX_BASE_LO = 8'hC2;
  localparam logic [CFG_W-1:0] IDX_BASE_HI = 8'hC3;
  localparam logic [CFG_W-1:0] IDX_SIZE    = 8'hC4;

  // Control byte, bit 0 is pin_en.
  typedef struct packed {
    logic main_in_smm;
    logic smm_in_norm;
    logic pin_en;
  } smm_ctl_t;

  localparam int CTL_W = $bits(smm_ctl_t);

endpackage

// File: rtl/smm_cfg_port.sv
module smm_cfg_port
  import smm_steer_pkg::*;
#(
  parameter int DW = CFG_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idx_we,
  input  logic            data_we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output smm_ctl_t        ctl,
  output logic [2*DW-1:0] base_page,
  output logic [DW-1:0]   size_pages
);

  logic [DW-1:0] idx_q;
  smm_ctl_t      ctl_q;
  logic [DW-1:0] base_lo_q;
  logic [DW-1:0] base_hi_q;
  logic [DW-1:0] size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      ctl_q     <= '0;
      base_lo_q <= '0;
      base_hi_q <= '0;
      size_q    <= '0;
    end else begin
      if (idx_we) begin
        idx_q <= wdata;
      end
      if (data_we) begin
        case (idx_q)
          DW'(IDX_CTRL):    ctl_q     <= smm_ctl_t'(wdata[CTL_W-1:0]);
          DW'(IDX_BASE_LO): base_lo_q <= wdata;
          DW'(IDX_BASE_HI): base_hi_q <= wdata;
          DW'(IDX_SIZE):    size_q    <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx_q)
      DW'(IDX_CTRL):    rdata = DW'(ctl_q);
      DW'(IDX_BASE_LO): rdata = base_lo_q;
      DW'(IDX_BASE_HI): rdata = base_hi_q;
      DW'(IDX_SIZE):    rdata = size_q;
      default:          rdata = '1;
    endcase
  end

  assign ctl        = ctl_q;
  assign base_page  = {base_hi_q, base_lo_q};
  assign size_pages = size_q;

endmodule

// File: rtl/smm_mode_ctl.sv
module smm_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic smi_n,
  input  logic resume,
  input  logic pin_en,
  input  logic smm_in_norm,
  output logic in_smm
);

  logic smi_q;
  logic smi_fell;
  logic smi_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smi_q <= 1'b1;
    end else begin
      smi_q <= smi_n;
    end
  end

  assign smi_fell = smi_q & ~smi_n;
  assign smi_take = smi_fell & pin_en & ~smm_in_norm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_smm <= 1'b0;
    end else if (!in_smm) begin
      if (smi_take) in_smm <= 1'b1;
    end else if (resume) begin
      in_smm <= 1'b0;
    end
  end

endmodule

// File: rtl/smm_region_hit.sv
module smm_region_hit #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int BASE_W     = 16,
  parameter int SIZE_W     = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base_page,
  input  logic [SIZE_W-1:0] size_pages,
  output logic              hit
);

  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam int CMP_W  = PAGE_W + 1;

  logic [CMP_W-1:0] page;
  logic [CMP_W-1:0] lo;
  logic [CMP_W-1:0] hi;

  assign page = CMP_W'(addr[ADDR_W-1:PAGE_SHIFT]);
  assign lo   = CMP_W'(base_page);
  assign hi   = lo + CMP_W'(size_pages);
  assign hit  = (size_pages != '0) && (page >= lo) && (page < hi);

endmodule

// File: rtl/smm_route_stage.sv
module smm_route_stage #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_smm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_smm
);

  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_smm   <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_addr  <= in_addr;
        out_smm   <= in_smm;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/smm_strobe_steer.sv
module smm_strobe_steer
  import smm_steer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_idx_we,
  input  logic              cfg_data_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              smi_n_i,
  input  logic              resume_i,
  input  logic              smm_insn_i,
  output logic              insn_fault_o,
  output logic              smm_mode_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_code_i,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              norm_strobe_o,
  output logic              smm_strobe_o,
  output logic              smm_strobe_oe_o
);

  localparam int BASE_W = 2 * CFG_W;

  smm_ctl_t          ctl;
  logic [BASE_W-1:0] base_page;
  logic [CFG_W-1:0]  size_pages;
  logic              in_smm;
  logic              hit;
  logic              route_smm;
  logic              beat_smm;

  smm_cfg_port #(.DW(CFG_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_we     (cfg_idx_we),
    .data_we    (cfg_data_we),
    .wdata      (cfg_wdata),
    .rdata      (cfg_rdata),
    .ctl        (ctl),
    .base_page  (base_page),
    .size_pages (size_pages)
  );

  smm_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .smi_n       (smi_n_i),
    .resume      (resume_i),
    .pin_en      (ctl.pin_en),
    .smm_in_norm (ctl.smm_in_norm),
    .in_smm      (in_smm)
  );

  smm_region_hit #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .BASE_W     (BASE_W),
    .SIZE_W     (CFG_W)
  ) u_hit (
    .addr       (req_addr_i),
    .base_page  (base_page),
    .size_pages (size_pages),
    .hit        (hit)
  );

  // Main-access bit governs SMM mode and so outranks the normal-mode bit.
  always_comb begin
    if (!ctl.pin_en) begin
      route_smm = 1'b0;
    end else if (!in_smm) begin
      route_smm = ctl.smm_in_norm & hit;
    end else begin
      route_smm = ~(ctl.main_in_smm & hit & ~req_code_i);
    end
  end

  smm_route_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid_i),
    .in_ready  (req_ready_o),
    .in_addr   (req_addr_i),
    .in_smm    (route_smm),
    .out_valid (bus_valid_o),
    .out_ready (bus_ready_i),
    .out_addr  (bus_addr_o),
    .out_smm   (beat_smm)
  );

  assign norm_strobe_o   = bus_valid_o & ~beat_smm;
  assign smm_strobe_o    = bus_valid_o & beat_smm & ctl.pin_en;
  assign smm_strobe_oe_o = ctl.pin_en;
  assign smm_mode_o      = in_smm;
  assign insn_fault_o    = smm_insn_i & (~ctl.pin_en | (~in_smm & ~ctl.smm_in_norm));

endmodule

// File: rtl/smm_steer_chk.sv
module smm_steer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_smm,
  input logic              pin_en,
  input logic              smm_in_norm,
  input logic              smi_n_i,
  input logic              resume_i,
  input logic              smm_insn_i,
  input logic              insn_fault_o,
  input logic              req_ready_o,
  input logic              bus_valid_o,
  input logic              bus_ready_i,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              norm_strobe_o,
  input logic              smm_strobe_o
);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o |-> (norm_strobe_o ^ smm_strobe_o));

  p_pin_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_smm && !pin_en) |=> !in_smm);

  p_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_smm && $fell(smi_n_i) && pin_en && !smm_in_norm) |=> in_smm);

  p_norm_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_smm && smm_in_norm) |=> !in_smm);

  p_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_smm && !resume_i) |=> in_smm);

  p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_smm && resume_i) |=> !in_smm);

  p_fault_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_insn_i && !pin_en) |-> insn_fault_o);

  p_fault_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_insn_i && pin_en && in_smm) |-> !insn_fault_o);

  p_stall_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !bus_ready_i) |-> !req_ready_o);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !bus_ready_i) |=> (bus_valid_o && $stable(bus_addr_o)));

endmodule

bind smm_strobe_steer smm_steer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_smm        (in_smm),
  .pin_en        (ctl.pin_en),
  .smm_in_norm   (ctl.smm_in_norm),
  .smi_n_i       (smi_n_i),
  .resume_i      (resume_i),
  .smm_insn_i    (smm_insn_i),
  .insn_fault_o  (insn_fault_o),
  .req_ready_o   (req_ready_o),
  .bus_valid_o   (bus_valid_o),
  .bus_ready_i   (bus_ready_i),
  .bus_addr_o    (bus_addr_o),
  .norm_strobe_o (norm_strobe_o),
  .smm_strobe_o  (smm_strobe_o)
);

// File: tb/test_smm_strobe_steer.sv
module test_smm_strobe_steer;

  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              cfg_idx_we, cfg_data_we;
  logic [7:0]        cfg_wdata, cfg_rdata;
  logic              smi_n_i, resume_i, smm_insn_i, insn_fault_o, smm_mode_o;
  logic              req_valid_i, req_ready_o, req_code_i;
  logic [ADDR_W-1:0] req_addr_i, bus_addr_o;
  logic              bus_valid_o, bus_ready_i;
  logic              norm_strobe_o, smm_strobe_o, smm_strobe_oe_o;

  smm_strobe_steer #(.ADDR_W(ADDR_W)) i_smm_strobe_steer (.*);

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  // Model state, kept from the requirements.
  logic [2:0]  m_ctl  = '0;
  logic [15:0] m_base = '0;
  logic [7:0]  m_size = '0;
  logic        m_mode = 1'b0;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic              smm;
    string             tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic m_hit(input logic [ADDR_W-1:0] a);
    logic [20:0] pg, lo, hi;
    pg = {1'b0, a[31:12]};
    lo = 21'(m_base);
    hi = lo + 21'(m_size);
    return (m_size != 0) && (pg >= lo) && (pg < hi);
  endfunction

  function automatic logic m_route(input logic [ADDR_W-1:0] a, input logic code);
    if (!m_ctl[0]) return 1'b0;
    if (!m_mode)   return m_ctl[1] & m_hit(a);
    return !(m_ctl[2] & m_hit(a) & !code);
  endfunction

  // Monitor: pops one expected item per handshaken beat.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && bus_valid_o && bus_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11", "unexpected beat", bus_addr_o, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(bus_addr_o == e.addr, e.tag, "beat address", bus_addr_o, e.addr);
          check(smm_strobe_o == e.smm && norm_strobe_o == !e.smm, e.tag,
                "strobe (smm,norm)", {smm_strobe_o, norm_strobe_o}, {e.smm, !e.smm});
        end
      end
    end
  end

  // Driver: starts and ends at a falling edge.
  task automatic send(input logic [ADDR_W-1:0] a, input logic code, input string tag);
    exp_t e;
    bit ok;
    e.addr = a; e.smm = m_route(a, code); e.tag = tag;
    exp_q.push_back(e);
    req_valid_i = 1'b1; req_addr_i = a; req_code_i = code;
    forever begin
      #1 ok = req_ready_o;
      @(posedge clk);
      @(negedge clk);
      if (ok) break;
    end
    req_valid_i = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R11", "queue drained", exp_q.size(), 0);
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] val);
    cfg_idx_we = 1'b1; cfg_wdata = idx;
    @(negedge clk);
    cfg_idx_we = 1'b0; cfg_data_we = 1'b1; cfg_wdata = val;
    @(negedge clk);
    cfg_data_we = 1'b0;
    case (idx)
      8'hC1: m_ctl = val[2:0];
      8'hC2: m_base[7:0] = val;
      8'hC3: m_base[15:8] = val;
      8'hC4: m_size = val;
      default: ;
    endcase
  endtask

  task automatic cfg_read(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    cfg_idx_we = 1'b1; cfg_wdata = idx;
    @(negedge clk);
    cfg_idx_we = 1'b0;
    #1 check(cfg_rdata == exp, tag, "config read", cfg_rdata, exp);
    @(negedge clk);
  endtask

  task automatic smi_pulse();
    smi_n_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    smi_n_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic insn_try(input logic exp, input string tag);
    smm_insn_i = 1'b1;
    #1 check(insn_fault_o == exp, tag, "invalid-opcode flag", insn_fault_o, exp);
    @(negedge clk);
    smm_insn_i = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  // Window: pages 30h..33h, i.e. 0003_0000h..0003_3FFFh.
  localparam logic [31:0] A_BELOW = 32'h0002_FFFC;
  localparam logic [31:0] A_FIRST = 32'h0003_0000;
  localparam logic [31:0] A_LAST  = 32'h0003_3FFC;
  localparam logic [31:0] A_PAST  = 32'h0003_4000;

  initial begin
    rst_n = 1'b0; cfg_idx_we = 0; cfg_data_we = 0; cfg_wdata = 0;
    smi_n_i = 1; resume_i = 0; smm_insn_i = 0;
    req_valid_i = 0; req_addr_i = 0; req_code_i = 0; bus_ready_i = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(smm_mode_o == 0 && bus_valid_o == 0 && smm_strobe_oe_o == 0, "R1",
          "reset outputs", {smm_mode_o, bus_valid_o, smm_strobe_oe_o}, 0);
    cfg_read(8'hC1, 8'h00, "R1");
    cfg_read(8'hC2, 8'h00, "R1");
    cfg_read(8'hC4, 8'h00, "R1");

    // R2 unknown index
    cfg_write(8'hC7, 8'h5A);
    cfg_read(8'hC7, 8'hFF, "R2");
    cfg_read(8'h00, 8'hFF, "R2");
    cfg_read(8'hC1, 8'h00, "R2");
    cfg_read(8'hC2, 8'h00, "R2");

    cfg_write(8'hC2, 8'h30);
    cfg_write(8'hC3, 8'h00);
    cfg_write(8'hC4, 8'h04);
    cfg_read(8'hC2, 8'h30, "R1");
    cfg_read(8'hC4, 8'h04, "R1");

    // R7 pin disabled
    cfg_write(8'hC1, 8'h06);
    cfg_read(8'hC1, 8'h06, "R1");
    check(smm_strobe_oe_o == 0, "R7", "strobe enable off", smm_strobe_oe_o, 0);
    send(A_FIRST, 1'b0, "R7");
    drain();
    insn_try(1'b1, "R10");
    cfg_write(8'hC1, 8'h00);
    smi_pulse();
    check(smm_mode_o == 0, "R7", "SMI ignored without pin", smm_mode_o, 0);

    // R4 normal mode, SMM access bit clear
    cfg_write(8'hC1, 8'h01);
    check(smm_strobe_oe_o == 1, "R7", "strobe enable on", smm_strobe_oe_o, 1);
    send(A_FIRST, 1'b0, "R4");
    drain();
    insn_try(1'b1, "R10");

    // R3/R4 window boundaries with SMM access enabled
    cfg_write(8'hC1, 8'h03);
    send(A_BELOW, 1'b0, "R3");
    send(A_FIRST, 1'b0, "R3");
    send(A_LAST,  1'b1, "R3");
    send(A_PAST,  1'b0, "R3");
    drain();
    insn_try(1'b0, "R10");
    smi_pulse();
    check(smm_mode_o == 0, "R8", "SMI ignored with normal-mode access", smm_mode_o, 0);

    // R3 empty window
    cfg_write(8'hC4, 8'h00);
    send(A_FIRST, 1'b0, "R3");
    drain();
    cfg_write(8'hC4, 8'h04);

    // R8 entry
    cfg_write(8'hC1, 8'h01);
    smi_n_i = 1'b0;
    @(negedge clk);
    check(smm_mode_o == 1, "R8", "SMM entered next cycle", smm_mode_o, 1);
    m_mode = 1'b1;
    smi_n_i = 1'b1;
    @(negedge clk);
    insn_try(1'b0, "R10");

    // R5 SMM mode, main access clear
    send(A_PAST,  1'b0, "R5");
    send(A_FIRST, 1'b0, "R5");
    send(A_FIRST, 1'b1, "R5");
    drain();
    smi_pulse();
    check(smm_mode_o == 1, "R8", "second SMI ignored", smm_mode_o, 1);

    // R6 main access set
    cfg_write(8'hC1, 8'h05);
    send(A_FIRST, 1'b0, "R6");
    send(A_LAST,  1'b1, "R6");
    send(A_BELOW, 1'b0, "R6");
    drain();
    cfg_write(8'hC1, 8'h07);
    send(A_LAST, 1'b0, "R6");
    drain();

    // R11 back-pressure
    bus_ready_i = 1'b0;
    fork
      begin
        send(A_PAST,  1'b0, "R11");
        send(A_FIRST, 1'b0, "R11");
      end
      begin
        repeat (4) @(negedge clk);
        #1;
        check(bus_valid_o == 1 && bus_addr_o == A_PAST, "R11", "stalled beat held",
              bus_addr_o, A_PAST);
        check(smm_strobe_o == 1, "R11", "stalled strobe held", smm_strobe_o, 1);
        check(req_ready_o == 0, "R11", "ready low while stalled", req_ready_o, 0);
        @(negedge clk);
        bus_ready_i = 1'b1;
      end
    join
    drain();

    // R9 resume
    resume_i = 1'b1;
    @(negedge clk);
    resume_i = 1'b0;
    check(smm_mode_o == 0, "R9", "normal mode after resume", smm_mode_o, 0);
    m_mode = 1'b0;
    send(A_FIRST, 1'b0, "R4");
    send(A_PAST,  1'b0, "R4");
    drain();

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule